// File: doc/BRIEF.md
# NAND Cache Program Engine

This block models, on the device side, the two-stage write pipeline of a NAND flash die. A host drives command, address and data cycles over an 8-bit bus. A load command opens a page. It is followed by two column bytes, three row bytes and the page data. The data is collected in a cache register. A cache-confirm command moves the cache contents into a data register, and a timed array-programming countdown then starts. While that countdown runs, the host can already load the next page. A final-confirm command ends the run in the manner of an ordinary page program.

The device reports its state in two ways. The first is an active-low busy line. The second is a status byte. That byte separates cache readiness from array readiness, and it carries one pass/fail bit for the previous page and one for the current page. Array failures come from an injection input that is sampled when a page enters the data register. Each finished page produces a one-cycle commit pulse. The pulse carries the page's row, the byte sum of its contents and its pass/fail result, and it stands in for real cell storage.

Top module: `nand_cache_pgm`

## Requirements
- R1: A command byte 80h opens a load. The next five address cycles give the column (low byte first, two bytes) and the row (low byte first, three bytes). Data cycles after that are written into the cache starting at that column, one byte per cycle, and rb_n stays high while loading.
- R2: A cache-confirm 15h accepted while the array is idle drives rb_n low for exactly XFER_CYC cycles. Array programming of that page then runs for PROG_CYC cycles, with rb_n high.
- R3: A 15h accepted while the array is still programming keeps rb_n low until that programming ends, and then for XFER_CYC more cycles.
- R4: A final-confirm 10h drives rb_n low until array programming of its own page completes. From an idle array this is XFER_CYC + PROG_CYC cycles.
- R5: Command bytes 70h and 78h both place the status byte on bus_dout, and both are accepted while busy. bus_dout holds the status byte until another command byte is accepted. It reads 00h outside status mode and after reset.
- R6: In the status byte, bit 6 is 1 when no cache transfer is pending. Bit 5 is 1 when, in addition, the array is not programming. Bits 7 and 4 to 2 read 0.
- R7: fail_inject is sampled in the cycle a page enters the data register. A page that fails sets status bit 0 when its programming ends. At each transfer, bit 1 takes the value that bit 0 held, which is the result of page N-1.
- R8: Both error bits stay set across later passing pages. They are cleared only by an 80h issued when no cache sequence is open and the array is idle. A sequence opens with an accepted 15h and closes with a 10h.
- R9: A 15h whose block (row shifted right by PG_BITS) differs from the block of the open sequence starts no transfer, leaves rb_n high, discards the loaded page and sets status bit 0.
- R10: Data bytes at or beyond column PAGE_BYTES are ignored. Page bytes that are not written keep the value FFh set by 80h.
- R11: At the end of each array programming, commit_valid pulses for one cycle. The pulse carries the page row, the modular sum of its PAGE_BYTES bytes and its fail flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | One bus write cycle |
| bus_cle | input | 1 | Current write is a command byte |
| bus_ale | input | 1 | Current write is an address byte |
| bus_din | input | 8 | Bus write byte |
| fail_inject | input | 1 | Makes the page entering the data register fail |
| bus_dout | output | 8 | Status byte in status mode, else 00h |
| rb_n | output | 1 | Ready (1) / busy (0) |
| commit_valid | output | 1 | One-cycle pulse at end of array programming |
| commit_row | output | 24 | Row address of the committed page |
| commit_sum | output | SUM_W | Byte sum of the committed page |
| commit_fail | output | 1 | Committed page failed |

## Verification
The hardest situation to reach is a second confirm that arrives while the array is still busy with the first page. It must be held off, and the pass/fail result of the first page must then move into the previous-page bit. The bench reaches it by loading a short second page at once after the first transfer ends. This lands the second 15h well inside the programming window. The bench measures the release cycle against the first transfer's end plus PROG_CYC plus XFER_CYC. A sweep over every start column and load length, including columns past the page end, checks cache placement and FFh fill through the commit sum.

// File: rtl/nand_cpk.sv
package nand_cpk;
    localparam logic [7:0] OP_LOAD   = 8'h80;
    localparam logic [7:0] OP_CACHE  = 8'h15;
    localparam logic [7:0] OP_FINAL  = 8'h10;
    localparam logic [7:0] OP_STAT_A = 8'h70;
    localparam logic [7:0] OP_STAT_B = 8'h78;
    localparam int COL_CYCLES = 2;

    typedef struct packed {
        logic ld;
        logic cch;
        logic fin;
        logic stat;
        logic other;
        logic addr;
        logic data;
    } bus_ev_t;
endpackage

// File: rtl/nand_bus_dec.sv
module nand_bus_dec
    import nand_cpk::*;
(
    input  logic       we,
    input  logic       cle,
    input  logic       ale,
    input  logic [7:0] din,
    input  logic       busy,
    output bus_ev_t    ev
);
    logic cmd_cyc;

    always_comb begin
        cmd_cyc = we && cle && !ale;
        ev      = '0;
        ev.stat = cmd_cyc && (din == OP_STAT_A || din == OP_STAT_B);
        if (cmd_cyc && !busy && !ev.stat) begin
            ev.ld    = (din == OP_LOAD);
            ev.cch   = (din == OP_CACHE);
            ev.fin   = (din == OP_FINAL);
            ev.other = !(ev.ld || ev.cch || ev.fin);
        end
        ev.addr = we && ale && !cle && !busy;
        ev.data = we && !cle && !ale && !busy;
    end
endmodule

// File: rtl/nand_cache_reg.sv
module nand_cache_reg #(
    parameter int PAGE_BYTES = 8,
    parameter int COL_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    col_set,
    input  logic [COL_W-1:0]        col_start,
    input  logic                    wr,
    input  logic [7:0]              wdata,
    output logic [PAGE_BYTES*8-1:0] page
);
    localparam int PTR_W = $clog2(PAGE_BYTES + 1);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(PAGE_BYTES);

    typedef struct packed {
        logic [PAGE_BYTES*8-1:0] bytes;
        logic [PTR_W-1:0]        ptr;
    } cache_st_t;

    cache_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d.bytes = '1;
            s_d.ptr   = PTR_END;
        end else if (col_set) begin
            s_d.ptr = (col_start >= COL_W'(PAGE_BYTES)) ? PTR_END : col_start[PTR_W-1:0];
        end else if (wr && s_q.ptr != PTR_END) begin
            s_d.bytes[s_q.ptr*8 +: 8] = wdata;
            s_d.ptr = s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.bytes <= '1;
            s_q.ptr   <= PTR_END;
        end else begin
            s_q <= s_d;
        end
    end

    assign page = s_q.bytes;

    // R10
    overrun_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !clr && !col_set && s_q.ptr == PTR_END) |=> $stable(page));
endmodule

// File: rtl/nand_array_eng.sv
module nand_array_eng #(
    parameter int PAGE_BYTES = 8,
    parameter int ROW_W      = 24,
    parameter int PROG_CYC   = 24,
    parameter int SUM_W      = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [PAGE_BYTES*8-1:0] page_in,
    input  logic [ROW_W-1:0]        row_in,
    input  logic                    fail_in,
    output logic                    busy,
    output logic                    fin,
    output logic                    fin_fail,
    output logic                    done_valid,
    output logic [ROW_W-1:0]        done_row,
    output logic [SUM_W-1:0]        done_sum,
    output logic                    done_fail
);
    localparam int CNT_W = $clog2(PROG_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(PROG_CYC);

    typedef struct packed {
        logic                    busy;
        logic [CNT_W-1:0]        cnt;
        logic [PAGE_BYTES*8-1:0] bytes;
        logic [ROW_W-1:0]        row;
        logic                    fail;
        logic                    dv;
        logic [ROW_W-1:0]        drow;
        logic [SUM_W-1:0]        dsum;
        logic                    dfail;
    } arr_st_t;

    arr_st_t s_d, s_q;
    logic [SUM_W-1:0] page_sum;

    always_comb begin
        page_sum = '0;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            page_sum = page_sum + SUM_W'(s_q.bytes[i*8 +: 8]);
        end
    end

    always_comb begin
        s_d    = s_q;
        s_d.dv = 1'b0;
        fin    = s_q.busy && (s_q.cnt == CNT_W'(1));
        if (start) begin
            s_d.busy  = 1'b1;
            s_d.cnt   = CNT_LOAD;
            s_d.bytes = page_in;
            s_d.row   = row_in;
            s_d.fail  = fail_in;
        end else if (s_q.busy) begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (fin) begin
                s_d.busy  = 1'b0;
                s_d.dv    = 1'b1;
                s_d.drow  = s_q.row;
                s_d.dsum  = page_sum;
                s_d.dfail = s_q.fail;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.bytes <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy       = s_q.busy;
    assign fin_fail   = s_q.fail;
    assign done_valid = s_q.dv;
    assign done_row   = s_q.drow;
    assign done_sum   = s_q.dsum;
    assign done_fail  = s_q.dfail;

    // R3
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy);
    // R2
    prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != CNT_W'(1)) |=> s_q.busy);
    // R11
    commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);
endmodule

// File: rtl/nand_cache_pgm.sv
module nand_cache_pgm
    import nand_cpk::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int ROW_BYTES  = 3,
    parameter int PG_BITS    = 2,
    parameter int XFER_CYC   = 3,
    parameter int PROG_CYC   = 24,
    parameter int SUM_W      = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic                   bus_cle,
    input  logic                   bus_ale,
    input  logic [7:0]             bus_din,
    input  logic                   fail_inject,
    output logic [7:0]             bus_dout,
    output logic                   rb_n,
    output logic                   commit_valid,
    output logic [8*ROW_BYTES-1:0] commit_row,
    output logic [SUM_W-1:0]       commit_sum,
    output logic                   commit_fail
);
    localparam int ROW_W    = 8 * ROW_BYTES;
    localparam int ADDR_CYC = COL_CYCLES + ROW_BYTES;
    localparam int ACNT_W   = $clog2(ADDR_CYC + 1);
    localparam int XC_W     = $clog2(XFER_CYC + 1);
    localparam int BLK_W    = ROW_W - PG_BITS;
    localparam logic [ACNT_W-1:0] ACNT_END = ACNT_W'(ADDR_CYC);

    typedef struct packed {
        logic              stat;
        logic              loading;
        logic [ACNT_W-1:0] acnt;
        logic [7:0]        col_lo;
        logic [ROW_W-1:0]  row;
        logic              pend;
        logic [XC_W-1:0]   xcnt;
        logic              fin_pend;
        logic              seq_act;
        logic [BLK_W-1:0]  seq_blk;
        logic              cur_fail;
        logic              prev_fail;
    } ctl_t;

    ctl_t c_d, c_q;
    bus_ev_t ev;
    logic busy, start, cache_clr, col_set, cache_wr;
    logic addr_done, blk_miss, abusy, afin, afail;
    logic [BLK_W-1:0] row_blk;
    logic [PAGE_BYTES*8-1:0] cache_page;

    assign busy = c_q.pend || c_q.fin_pend;
    assign rb_n = !busy;

    nand_bus_dec dec_i (
        .we   (bus_we),
        .cle  (bus_cle),
        .ale  (bus_ale),
        .din  (bus_din),
        .busy (busy),
        .ev   (ev)
    );

    always_comb begin
        c_d       = c_q;
        start     = 1'b0;
        cache_clr = 1'b0;
        col_set   = 1'b0;
        addr_done = c_q.loading && (c_q.acnt == ACNT_END);
        row_blk   = c_q.row[ROW_W-1:PG_BITS];
        blk_miss  = c_q.seq_act && (row_blk != c_q.seq_blk);
        cache_wr  = ev.data && addr_done;

        if (ev.stat) c_d.stat = 1'b1;
        if (ev.ld || ev.cch || ev.fin || ev.other) c_d.stat = 1'b0;

        if (ev.ld) begin
            c_d.loading = 1'b1;
            c_d.acnt    = '0;
            cache_clr   = 1'b1;
            if (!c_q.seq_act && !abusy) begin
                c_d.cur_fail  = 1'b0;
                c_d.prev_fail = 1'b0;
            end
        end

        if (ev.addr && c_q.loading && c_q.acnt != ACNT_END) begin
            if (c_q.acnt == '0) begin
                c_d.col_lo = bus_din;
            end else if (c_q.acnt == ACNT_W'(1)) begin
                col_set = 1'b1;
            end else begin
                c_d.row[(int'(c_q.acnt) - COL_CYCLES)*8 +: 8] = bus_din;
            end
            c_d.acnt = c_q.acnt + 1'b1;
        end

        if (ev.cch && addr_done) begin
            c_d.loading = 1'b0;
            if (blk_miss) begin
                c_d.cur_fail = 1'b1;
            end else begin
                c_d.pend    = 1'b1;
                c_d.xcnt    = XC_W'(XFER_CYC);
                c_d.seq_act = 1'b1;
                c_d.seq_blk = row_blk;
            end
        end

        if (ev.fin && addr_done) begin
            c_d.loading  = 1'b0;
            c_d.pend     = 1'b1;
            c_d.xcnt     = XC_W'(XFER_CYC);
            c_d.fin_pend = 1'b1;
            c_d.seq_act  = 1'b0;
        end

        if (c_q.pend && !abusy) begin
            if (c_q.xcnt == XC_W'(1)) begin
                c_d.pend      = 1'b0;
                start         = 1'b1;
                c_d.prev_fail = c_q.cur_fail;
            end else begin
                c_d.xcnt = c_q.xcnt - 1'b1;
            end
        end

        if (afin) begin
            if (afail) c_d.cur_fail = 1'b1;
            if (c_q.fin_pend && !c_q.pend) c_d.fin_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    nand_cache_reg #(
        .PAGE_BYTES (PAGE_BYTES),
        .COL_W      (16)
    ) cache_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cache_clr),
        .col_set   (col_set),
        .col_start ({bus_din, c_q.col_lo}),
        .wr        (cache_wr),
        .wdata     (bus_din),
        .page      (cache_page)
    );

    nand_array_eng #(
        .PAGE_BYTES (PAGE_BYTES),
        .ROW_W      (ROW_W),
        .PROG_CYC   (PROG_CYC),
        .SUM_W      (SUM_W)
    ) array_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .page_in    (cache_page),
        .row_in     (c_q.row),
        .fail_in    (fail_inject),
        .busy       (abusy),
        .fin        (afin),
        .fin_fail   (afail),
        .done_valid (commit_valid),
        .done_row   (commit_row),
        .done_sum   (commit_sum),
        .done_fail  (commit_fail)
    );

    assign bus_dout = c_q.stat ? {1'b0, !c_q.pend, !(c_q.pend || abusy), 3'b000,
                                  c_q.prev_fail, c_q.cur_fail} : 8'h00;

    // R3
    holdoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.pend && abusy) |=> (c_q.pend && $stable(c_q.xcnt)));
    // R2
    xfer_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !c_q.fin_pend) |=> rb_n);
    // R4
    final_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.fin_pend && !afin) |=> !rb_n);
    // R9
    blk_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.cch && addr_done && blk_miss) |=> (rb_n && c_q.cur_fail));
endmodule

// File: tb/nand_cache_pgm_tb.sv
module nand_cache_pgm_tb_top;
    localparam int PB   = 8;
    localparam int XFER = 3;
    localparam int PROG = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0, bus_cle = 1'b0, bus_ale = 1'b0;
    logic [7:0]  bus_din = 8'h00;
    logic        fail_inject = 1'b0;
    logic [7:0]  bus_dout;
    logic        rb_n;
    logic        commit_valid;
    logic [23:0] commit_row;
    logic [15:0] commit_sum;
    logic        commit_fail;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int commits = 0;
    int last_sum = 0;
    int last_row = 0;
    int last_fail = 0;

    always #10 clk = !clk;

    nand_cache_pgm #(
        .PAGE_BYTES (PB),
        .ROW_BYTES  (3),
        .PG_BITS    (2),
        .XFER_CYC   (XFER),
        .PROG_CYC   (PROG),
        .SUM_W      (16)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_we       (bus_we),
        .bus_cle      (bus_cle),
        .bus_ale      (bus_ale),
        .bus_din      (bus_din),
        .fail_inject  (fail_inject),
        .bus_dout     (bus_dout),
        .rb_n         (rb_n),
        .commit_valid (commit_valid),
        .commit_row   (commit_row),
        .commit_sum   (commit_sum),
        .commit_fail  (commit_fail)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (commit_valid) begin
            commits   = commits + 1;
            last_sum  = int'(commit_sum);
            last_row  = int'(commit_row);
            last_fail = int'(commit_fail);
        end
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog (all requirements): got cycle %0d expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic c, input logic a, input logic [7:0] d);
        bus_we = 1'b1; bus_cle = c; bus_ale = a; bus_din = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_cle = 1'b0; bus_ale = 1'b0; bus_din = 8'h00;
    endtask

    function automatic logic [7:0] vbyte(input int k, input int i);
        return 8'(k * 37 + i * 11 + 5);
    endfunction

    function automatic int exp_sum(input int col, input int len, input int k);
        int s = 0;
        for (int b = 0; b < PB; b++) begin
            if (col < PB && b >= col && b < col + len) s += int'(vbyte(k, b - col));
            else s += 255;
        end
        return s;
    endfunction

    task automatic load_page(input int col, input int row, input int len, input int k);
        bus_wr(1'b1, 1'b0, 8'h80);
        bus_wr(1'b0, 1'b1, col[7:0]);
        bus_wr(1'b0, 1'b1, col[15:8]);
        bus_wr(1'b0, 1'b1, row[7:0]);
        bus_wr(1'b0, 1'b1, row[15:8]);
        bus_wr(1'b0, 1'b1, row[23:16]);
        for (int i = 0; i < len; i++) bus_wr(1'b0, 1'b0, vbyte(k, i));
    endtask

    task automatic wait_ready();
        while (!rb_n) @(negedge clk);
    endtask

    initial begin
        int c0, ta, tb, ncm;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rb_n == 1'b1, "R4 reset ready", int'(rb_n), 1);
        check(bus_dout == 8'h00, "R5 reset bus", int'(bus_dout), 0);
        check(commit_valid == 1'b0, "R11 reset commit", int'(commit_valid), 0);
        bus_wr(1'b1, 1'b0, 8'h70);
        check(bus_dout == 8'h60, "R6 idle status 70h", int'(bus_dout), 'h60);
        bus_wr(1'b1, 1'b0, 8'h78);
        check(bus_dout == 8'h60, "R5 idle status 78h", int'(bus_dout), 'h60);

        // R1 R4 R10 R11: sweep of start column and load length
        for (int col = 0; col < PB + 2; col++) begin
            for (int len = 0; len < PB + 2; len++) begin
                int k = col * 10 + len;
                ncm = commits;
                load_page(col, k + 8, len, k);
                check(rb_n == 1'b1, "R1 ready while loading", int'(rb_n), 1);
                bus_wr(1'b1, 1'b0, 8'h10);
                c0 = cyc;
                wait_ready();
                check(cyc == c0 + XFER + PROG, "R4 final busy length", cyc - c0, XFER + PROG);
                @(negedge clk);
                check(last_sum == exp_sum(col, len, k), "R10 page sum", last_sum, exp_sum(col, len, k));
                check(last_row == k + 8, "R1 row address", last_row, k + 8);
                check(commits == ncm + 1 && last_fail == 0, "R11 one commit", commits - ncm, 1);
            end
        end

        // R2 R6 R7: first cache confirm, failing page
        ncm = commits;
        load_page(0, 16, PB, 200);
        fail_inject = 1'b1;
        bus_wr(1'b1, 1'b0, 8'h15);
        c0 = cyc;
        bus_wr(1'b1, 1'b0, 8'h70);
        check(bus_dout == 8'h00, "R6 status during transfer", int'(bus_dout), 0);
        wait_ready();
        fail_inject = 1'b0;
        check(cyc == c0 + XFER, "R2 transfer busy length", cyc - c0, XFER);
        ta = cyc;
        check(bus_dout == 8'h40, "R6 cache ready array busy", int'(bus_dout), 'h40);

        // R3: second confirm held off
        load_page(2, 17, 3, 201);
        bus_wr(1'b1, 1'b0, 8'h15);
        wait_ready();
        check(cyc == ta + PROG + XFER, "R3 held-off release", cyc - ta, PROG + XFER);
        tb = cyc;
        @(negedge clk);
        check(commits == ncm + 1 && last_fail == 1, "R7 failed commit", last_fail, 1);
        check(last_row == 16 && last_sum == exp_sum(0, PB, 200), "R11 first page", last_sum, exp_sum(0, PB, 200));
        bus_wr(1'b1, 1'b0, 8'h70);
        check(bus_dout == 8'h43, "R7 N-1 fail bit", int'(bus_dout), 'h43);
        while (!bus_dout[5]) @(negedge clk);
        check(cyc == tb + PROG, "R6 array ready timing", cyc - tb, PROG);
        check(bus_dout == 8'h63, "R8 error sticky after pass", int'(bus_dout), 'h63);
        @(negedge clk);
        check(last_fail == 0 && last_sum == exp_sum(2, 3, 201), "R11 second page", last_sum, exp_sum(2, 3, 201));

        // R8: open sequence keeps, closed sequence clears
        load_page(1, 18, 2, 202);
        bus_wr(1'b1, 1'b0, 8'h70);
        check(bus_dout == 8'h63, "R8 open sequence keeps", int'(bus_dout), 'h63);
        bus_wr(1'b1, 1'b0, 8'h10);
        wait_ready();
        bus_wr(1'b1, 1'b0, 8'h70);
        check(bus_dout == 8'h63, "R8 kept through final", int'(bus_dout), 'h63);
        bus_wr(1'b1, 1'b0, 8'h80);
        bus_wr(1'b1, 1'b0, 8'h70);
        check(bus_dout == 8'h60, "R8 cleared by new load", int'(bus_dout), 'h60);

        // R9: block mismatch on 15h
        ncm = commits;
        load_page(0, 20, 4, 203);
        bus_wr(1'b1, 1'b0, 8'h15);
        wait_ready();
        load_page(0, 24, 4, 204);
        bus_wr(1'b1, 1'b0, 8'h15);
        check(rb_n == 1'b1, "R9 mismatch not busy", int'(rb_n), 1);
        bus_wr(1'b1, 1'b0, 8'h70);
        check(bus_dout == 8'h41, "R9 mismatch error bit", int'(bus_dout), 'h41);
        repeat (2 * (PROG + XFER)) @(negedge clk);
        check(commits == ncm + 1, "R9 rejected page not committed", commits - ncm, 1);
        check(last_row == 20, "R9 only first page committed", last_row, 20);
        load_page(0, 21, PB, 205);
        bus_wr(1'b1, 1'b0, 8'h10);
        wait_ready();
        @(negedge clk);
        check(last_row == 21 && last_sum == exp_sum(0, PB, 205), "R9 same block accepted", last_row, 21);
        check(last_fail == 0, "R7 passing page", last_fail, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule